// File: doc/BRIEF.md
# Printer Port Register Controller

This block puts a byte-wide printer port behind a small host register bus. The host writes an outgoing data byte, a control byte and reads a status byte. The control byte drives the strobe, auto-feed, init and select line signals and the direction of the data pins. The block also stands in for the printer's side of the handshake. A rising strobe, made while init and select are asserted, sends the latched data byte out as a one-cycle byte-valid pulse and clears the busy bit. After that, status reads step the acknowledge and busy bits through the pattern a polling driver expects.

A single level interrupt can be armed through the control byte. It is raised when a byte goes out and is dropped by the next handshake step or by disarming. Offsets other than data, status and control read as all ones, and writes to them do nothing.

Top module: `lpt_port_ctrl`

## Requirements
- R1: After reset, status reads 0xD9, control reads 0x0C, irq, byte_valid and bus_rvalid are 0, and the data pins are driven (pd_oe = 1).
- R2: A write to offset 0 latches the byte onto pd_out. A read of offset 0 returns that latch while control bit 5 (direction) is 0. With bit 5 set, the read returns the byte sampled from pd_in, and pd_oe equals the inverse of bit 5.
- R3: A write to offset 2 stores the full control byte, and a read of offset 2 returns it. Control bits 0, 1, 2 and 3 drive ln_strobe, ln_autofeed, ln_init and ln_select.
- R4: A control write with bit 2 (init) equal to 0 sets status to 0xD8. In that value, bit 7 (not-busy), bit 6 (ack), bit 4 (online) and bit 3 (no-error) are set, and bit 0 (timeout) is cleared.
- R5: A control write with bits 2, 3 and 0 all set clears status bit 7.
- R6: When such a write (R5) follows a control value whose bit 0 was 0, byte_valid is high for exactly one cycle and byte_data carries the offset-0 latch.
- R7: A status read (offset 1) made while status bit 7 and control bit 0 are both 0 steps the handshake. If bit 6 is set, the read clears it. Otherwise, the read sets bits 6 and 7. Any other status read leaves status unchanged.
- R8: A status read returns the status value from before its own handshake step. Writes to offset 1 are ignored.
- R9: irq is set when a byte is sent (R6) by a control write with bit 4 (interrupt enable) set. It is cleared by a control write with bit 4 clear or by a handshake step (R7).
- R10: Reads of offsets 3 and above return 0xFF. Writes to them change no register.
- R11: Read data appears on bus_rdata with bus_rvalid high on the cycle after bus_rd. If bus_wr is high in the same cycle, the read is dropped and only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| pd_out | output | 8 | Outgoing data pins |
| pd_oe | output | 1 | Data pin drive enable (direction bit inverted) |
| pd_in | input | 8 | Incoming data pins |
| ln_strobe | output | 1 | Strobe line signal (control bit 0) |
| ln_autofeed | output | 1 | Auto-feed line signal (control bit 1) |
| ln_init | output | 1 | Init line signal (control bit 2) |
| ln_select | output | 1 | Select line signal (control bit 3) |
| byte_valid | output | 1 | One-cycle pulse when a byte is sent |
| byte_data | output | 8 | Byte sent with byte_valid |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with the default ADDR_W of 3. At that width the decoder sees five unused offsets (3 to 7), so the all-ones read and the ignored writes are exercised across a real range of addresses, not at a single one. Control bytes in the random phase are biased toward having init and select set. This makes strobe edges, busy clearing, the ack/busy stepping of status reads and the interrupt arm/clear paths frequent, beside the init-low forcing of status.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int DW = 8;

  localparam int OFS_DATA = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_CTRL = 2;

  localparam int ST_NBUSY  = 7;
  localparam int ST_ACK    = 6;
  localparam int ST_NERR   = 3;
  localparam int ST_ONLINE = 4;
  localparam int ST_TMO    = 0;

  localparam int CT_DIR   = 5;
  localparam int CT_IEN   = 4;
  localparam int CT_SELIN = 3;
  localparam int CT_INIT  = 2;
  localparam int CT_AFD   = 1;
  localparam int CT_STB   = 0;

  localparam logic [DW-1:0] STAT_RST  = 8'hD9;
  localparam logic [DW-1:0] STAT_INIT = 8'hD8;
  localparam logic [DW-1:0] CTRL_RST  = 8'h0C;
  localparam logic [DW-1:0] RD_NONE   = 8'hFF;

  typedef struct packed {
    logic wr_data;
    logic wr_ctrl;
    logic rd_data;
    logic rd_stat;
    logic rd_ctrl;
    logic rd_other;
  } lpt_dec_t;
endpackage

// File: rtl/lpt_bus_dec.sv
module lpt_bus_dec
  import lpt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output lpt_dec_t          dec
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

  logic rd_ok;
  logic hit_data, hit_stat, hit_ctrl;

  always_comb begin
    rd_ok    = rd & ~wr;
    hit_data = (addr == A_DATA);
    hit_stat = (addr == A_STAT);
    hit_ctrl = (addr == A_CTRL);
    dec.wr_data  = wr & hit_data;
    dec.wr_ctrl  = wr & hit_ctrl;
    dec.rd_data  = rd_ok & hit_data;
    dec.rd_stat  = rd_ok & hit_stat;
    dec.rd_ctrl  = rd_ok & hit_ctrl;
    dec.rd_other = rd_ok & ~(hit_data | hit_stat | hit_ctrl);
  end
endmodule

// File: rtl/lpt_ctl_reg.sv
module lpt_ctl_reg
  import lpt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  lpt_dec_t      dec,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] ctl_q,
  output logic [DW-1:0] dout_q,
  output logic [DW-1:0] din_q,
  output logic          ev_init,
  output logic          ev_ready,
  output logic          ev_launch,
  output logic          ien_wr,
  output logic          bvld_q,
  output logic [DW-1:0] bdat_q
);
  always_comb begin
    ev_init   = dec.wr_ctrl & ~wdata[CT_INIT];
    ev_ready  = dec.wr_ctrl & wdata[CT_INIT] & wdata[CT_SELIN] & wdata[CT_STB];
    ev_launch = ev_ready & ~ctl_q[CT_STB];
    ien_wr    = wdata[CT_IEN];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= CTRL_RST;
      dout_q <= '0;
      din_q  <= '0;
      bvld_q <= 1'b0;
      bdat_q <= '0;
    end else begin
      din_q  <= pin_in;
      bvld_q <= ev_launch;
      if (ev_launch) bdat_q <= dout_q;
      if (dec.wr_ctrl) ctl_q <= wdata;
      if (dec.wr_data) dout_q <= wdata;
    end
  end
endmodule

// File: rtl/lpt_status.sv
module lpt_status
  import lpt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctrl,
  input  logic          rd_stat,
  input  logic          ev_init,
  input  logic          ev_ready,
  input  logic          ev_launch,
  input  logic          ien_wr,
  input  logic          ctl_stb,
  output logic [DW-1:0] sts_q,
  output logic          irq_q
);
  logic          step;
  logic [DW-1:0] sts_d;
  logic          irq_d;

  always_comb begin
    step  = rd_stat & ~sts_q[ST_NBUSY] & ~ctl_stb;
    sts_d = sts_q;
    if (ev_init) begin
      sts_d = STAT_INIT;
    end else if (ev_ready) begin
      sts_d[ST_NBUSY] = 1'b0;
    end else if (step) begin
      if (sts_q[ST_ACK]) begin
        sts_d[ST_ACK] = 1'b0;
      end else begin
        sts_d[ST_ACK]   = 1'b1;
        sts_d[ST_NBUSY] = 1'b1;
      end
    end

    irq_d = irq_q;
    if (wr_ctrl && !ien_wr)        irq_d = 1'b0;
    else if (ev_launch && ien_wr)  irq_d = 1'b1;
    else if (step)                 irq_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= STAT_RST;
      irq_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/lpt_rd_mux.sv
module lpt_rd_mux
  import lpt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  lpt_dec_t      dec,
  input  logic [DW-1:0] ctl_q,
  input  logic [DW-1:0] sts_q,
  input  logic [DW-1:0] dout_q,
  input  logic [DW-1:0] din_q,
  output logic [DW-1:0] rdata_q,
  output logic          rvalid_q
);
  logic [DW-1:0] sel;
  logic          any_rd;

  always_comb begin
    any_rd = dec.rd_data | dec.rd_stat | dec.rd_ctrl | dec.rd_other;
    sel    = RD_NONE;
    if (dec.rd_data)      sel = ctl_q[CT_DIR] ? din_q : dout_q;
    else if (dec.rd_stat) sel = sts_q;
    else if (dec.rd_ctrl) sel = ctl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= any_rd;
      if (any_rd) rdata_q <= sel;
    end
  end
endmodule

// File: rtl/lpt_port_ctrl.sv
module lpt_port_ctrl
  import lpt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_rvalid,
  output logic [7:0]        pd_out,
  output logic              pd_oe,
  input  logic [7:0]        pd_in,
  output logic              ln_strobe,
  output logic              ln_autofeed,
  output logic              ln_init,
  output logic              ln_select,
  output logic              byte_valid,
  output logic [7:0]        byte_data,
  output logic              irq
);
  lpt_dec_t      dec;
  logic [DW-1:0] ctl_q, sts_q, dout_q, din_q;
  logic          ev_init, ev_ready, ev_launch, ien_wr;

  lpt_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .wr   (bus_wr),
    .rd   (bus_rd),
    .dec  (dec)
  );

  lpt_ctl_reg u_ctl (
    .clk       (clk),
    .rst       (rst),
    .dec       (dec),
    .wdata     (bus_wdata),
    .pin_in    (pd_in),
    .ctl_q     (ctl_q),
    .dout_q    (dout_q),
    .din_q     (din_q),
    .ev_init   (ev_init),
    .ev_ready  (ev_ready),
    .ev_launch (ev_launch),
    .ien_wr    (ien_wr),
    .bvld_q    (byte_valid),
    .bdat_q    (byte_data)
  );

  lpt_status u_sts (
    .clk       (clk),
    .rst       (rst),
    .wr_ctrl   (dec.wr_ctrl),
    .rd_stat   (dec.rd_stat),
    .ev_init   (ev_init),
    .ev_ready  (ev_ready),
    .ev_launch (ev_launch),
    .ien_wr    (ien_wr),
    .ctl_stb   (ctl_q[CT_STB]),
    .sts_q     (sts_q),
    .irq_q     (irq)
  );

  lpt_rd_mux u_rd (
    .clk      (clk),
    .rst      (rst),
    .dec      (dec),
    .ctl_q    (ctl_q),
    .sts_q    (sts_q),
    .dout_q   (dout_q),
    .din_q    (din_q),
    .rdata_q  (bus_rdata),
    .rvalid_q (bus_rvalid)
  );

  always_comb begin
    pd_out      = dout_q;
    pd_oe       = ~ctl_q[CT_DIR];
    ln_strobe   = ctl_q[CT_STB];
    ln_autofeed = ctl_q[CT_AFD];
    ln_init     = ctl_q[CT_INIT];
    ln_select   = ctl_q[CT_SELIN];
  end
endmodule

// File: rtl/lpt_port_chk.sv
module lpt_port_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              bus_rvalid,
  input logic              byte_valid,
  input logic              irq,
  input logic [7:0]        ctl_q,
  input logic [7:0]        sts_q
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2);

  logic wr_ctl, rd_sts, rd_unused;
  always_comb begin
    wr_ctl    = bus_wr && bus_addr == A_CTRL;
    rd_sts    = bus_rd && !bus_wr && bus_addr == A_STAT;
    rd_unused = bus_rd && !bus_wr && bus_addr > A_CTRL;
  end

  AST_INIT_FORCE: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && !bus_wdata[2]) |=> sts_q == 8'hD8); // R4
  AST_BUSY_CLR: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && bus_wdata[2] && bus_wdata[3] && bus_wdata[0]) |=> !sts_q[7]); // R5
  AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid); // R6
  AST_BYTE_GATE: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> (ctl_q[0] && ctl_q[2] && ctl_q[3])); // R6
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_ctl && !rd_sts) |=> $stable(sts_q)); // R7
  AST_IRQ_ARMED: assert property (@(posedge clk) disable iff (rst)
    irq |-> ctl_q[4]); // R9
  AST_UNUSED_RD: assert property (@(posedge clk) disable iff (rst)
    rd_unused |=> bus_rdata == 8'hFF); // R10
  AST_RD_VALID: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr) |=> bus_rvalid); // R11
  AST_RD_DROP: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> !bus_rvalid); // R11
endmodule

bind lpt_port_ctrl lpt_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .byte_valid (byte_valid),
  .irq        (irq),
  .ctl_q      (ctl_q),
  .sts_q      (sts_q)
);

// File: tb/tb_lpt_port_ctrl.sv
module tb_lpt_port_ctrl;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          bus_rvalid;
  logic [7:0]    pd_out, pd_in = 8'h00;
  logic          pd_oe, ln_strobe, ln_autofeed, ln_init, ln_select;
  logic          byte_valid, irq;
  logic [7:0]    byte_data;

  always #4 clk = ~clk;

  lpt_port_ctrl #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pd_out(pd_out), .pd_oe(pd_oe), .pd_in(pd_in), .ln_strobe(ln_strobe),
    .ln_autofeed(ln_autofeed), .ln_init(ln_init), .ln_select(ln_select),
    .byte_valid(byte_valid), .byte_data(byte_data), .irq(irq)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  logic [7:0] sts_m, ctl_m, dout_m, din_m;
  bit         pend_m;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      finish_run();
    end
  end

  // model of a control write; returns whether a byte should be sent
  function automatic bit model_write(input logic [AW-1:0] a, input logic [7:0] d,
                                     output logic [7:0] sent);
    bit go = 0;
    sent = dout_m;
    if (a == 3'd0) dout_m = d;
    else if (a == 3'd2) begin
      if (!d[2]) sts_m = 8'hD8;
      else if (d[3] && d[0]) begin
        sts_m[7] = 1'b0;
        go = !ctl_m[0];
      end
      if (!d[4]) pend_m = 0;
      else if (go) pend_m = 1;
      ctl_m = d;
    end
    return go;
  endfunction

  function automatic logic [7:0] model_read(input logic [AW-1:0] a);
    logic [7:0] r;
    if (a == 3'd0) r = ctl_m[5] ? din_m : dout_m;
    else if (a == 3'd1) begin
      r = sts_m;
      if (!sts_m[7] && !ctl_m[0]) begin
        if (sts_m[6]) sts_m[6] = 1'b0;
        else begin sts_m[6] = 1'b1; sts_m[7] = 1'b1; end
        pend_m = 0;
      end
    end else if (a == 3'd2) r = ctl_m;
    else r = 8'hFF;
    return r;
  endfunction

  task automatic check_pins();
    chk("R3 lines", {ln_select, ln_init, ln_autofeed, ln_strobe}, ctl_m[3:0]);
    chk("R2 pd_out", pd_out, dout_m);
    chk("R2 pd_oe", pd_oe, !ctl_m[5]);
    chk("R9 irq", irq, pend_m);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
    logic [7:0] sent;
    bit go;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    go = model_write(a, d, sent);
    chk("R6 byte_valid", byte_valid, go);
    if (go) chk("R6 byte_data", byte_data, sent);
    check_pins();
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string tag);
    logic [7:0] e;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    e = model_read(a);
    chk({tag, " rdata"}, bus_rdata, e);
    chk("R11 rvalid", bus_rvalid, 1'b1);
    check_pins();
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge clk);
    pd_in = v;
    @(negedge clk);
    din_m = v;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    sts_m = 8'hD9; ctl_m = 8'h0C; dout_m = 8'h00; din_m = 8'h00; pend_m = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 byte_valid", byte_valid, 0);
    chk("R1 rvalid", bus_rvalid, 0);
    chk("R1 pd_oe", pd_oe, 1);
    do_read(3'd1, "R1");
    do_read(3'd2, "R1");

    // byte transfer with interrupt, then the R7 handshake steps
    do_write(3'd0, 8'hA5);
    do_read(3'd0, "R2");
    do_write(3'd2, 8'h1C);
    do_write(3'd2, 8'h1D);      // R5 busy cleared, R6 byte sent, R9 irq set
    chk("R9 irq raised", irq, 1);
    do_read(3'd1, "R7");        // strobe still high: no step, R8 value
    chk("R9 irq held", irq, 1);
    do_write(3'd2, 8'h1C);
    do_read(3'd1, "R8");        // returns 0x59, clears ack
    chk("R9 irq cleared by step", irq, 0);
    do_read(3'd1, "R7");        // returns 0x19, sets ack and busy
    do_read(3'd1, "R7");        // 0xD9, no step

    // R4 init low forces status
    do_write(3'd2, 8'h08);
    do_read(3'd1, "R4");
    // R8 status writes ignored
    do_write(3'd1, 8'h00);
    do_read(3'd1, "R8");

    // R2 direction read
    do_write(3'd2, 8'h2C);
    set_pins(8'h3C);
    do_read(3'd0, "R2");

    // R10 unused offsets
    for (int a = 3; a < 8; a++) begin
      do_write(AW'(a), 8'h00);
      do_read(AW'(a), "R10");
    end
    do_read(3'd0, "R10");
    do_read(3'd2, "R10");

    // R11 read and write in the same cycle
    @(negedge clk);
    bus_addr = 3'd2; bus_wdata = 8'h0C; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    begin
      logic [7:0] s;
      void'(model_write(3'd2, 8'h0C, s));
    end
    chk("R11 dropped read", bus_rvalid, 0);
    do_read(3'd2, "R11");

    // constrained random phase
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a;
      logic [7:0]    d;
      int            k;
      k = $urandom_range(0, 9);
      a = AW'($urandom_range(0, 7));
      if (k < 4) a = 3'd2;
      else if (k < 7) a = 3'd1;
      d = 8'($urandom);
      if (a == 3'd2) begin
        d[7:6] = 2'b00;
        if ($urandom_range(0, 3) != 0) begin d[2] = 1'b1; d[3] = 1'b1; end
      end
      if ($urandom_range(0, 40) == 0) set_pins(8'($urandom));
      if ($urandom_range(0, 1) == 0) do_write(a, d);
      else if (a == 3'd0) do_read(a, "R2");
      else if (a == 3'd1) do_read(a, "R7");
      else if (a == 3'd2) do_read(a, "R3");
      else do_read(a, "R10");
    end
    finish_run();
  end
endmodule